// File: doc/BRIEF.md
# Configurable 4:2:2:4 Output Multiplexer

This block sits after a video processing core that delivers one luma sample, one blue-difference sample, one red-difference sample and one key (alpha) sample per clock. It formats them onto four 13-bit output ports, W, X, Y and Z, in one of three layouts chosen by a 2-bit format field. The first layout passes the three colour components straight through on separate ports. The second drives luma alone on W and puts the two chroma components, alternating, on X. The third puts chroma and luma, word by word, on W alone. The key is always driven on Z, delayed by the same number of clocks as the colour data in the active layout.

The interleave phase comes from a four-state group counter. Its states are GRP_CB, GRP_YA, GRP_CR and GRP_YB. Each clock it takes the "advance" transition (CB to YA to CR to YB and back to CB). A falling edge on the sync input takes the "restart" transition: the sample captured on that edge is treated as GRP_CB, and the counter then moves on to GRP_YA. In the fully interleaved layout the core runs at half rate, so each input word is held for two clocks. The sync fall must then land on a clock edge that is also a half-rate edge. A registered output strobe goes low on every clock that carries a blue-difference word.

Top module: `vid422_outmux`

## Requirements
- R1: While reset is asserted, and until the first clock edge after its release, all four data outputs are zero and out_sync is high.
- R2: With mode = 2'b11 (separate), the luma, blue-difference and red-difference inputs captured on edge n appear on out_w, out_x and out_y from edge n+2 onward. out_sync stays high.
- R3: With mode = 2'b10 (luma plus chroma), out_w carries luma with 2 clocks of delay and out_y is zero. For the sample at even index k, out_x carries the Cb of sample k. For the sample at odd index k+1, out_x carries the Cr of sample k. The chroma of odd samples is dropped.
- R4: With mode = 2'b01 (fully interleaved), a group whose first sample is captured on edge g appears on out_w on edges g+4, g+5, g+6 and g+7 as Cb(g), Y(g), Cr(g), Y(g+3). out_x and out_y are zero.
- R5: out_z carries in_key delayed by 2 clocks in modes 2'b11 and 2'b10, and by 4 clocks in mode 2'b01.
- R6: With mode = 2'b00 (reserved), out_w, out_x, out_y and out_z are zero and out_sync is high.
- R7: A sync fall is sync_in sampled high on one edge and low on the next. The sample captured on the edge where sync_in is first seen low gets index 0, which is group phase GRP_CB.
- R8: out_sync is low exactly on clocks where a Cb word is on out_x (mode 2'b10) or on out_w (mode 2'b01). Otherwise it is high, and it is always high in modes 2'b11 and 2'b00.
- R9: Without a sync fall, the phase runs freely with period 4 (parity period 2). The first sample captured after reset has phase GRP_CB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_in | input | 1 | Phase marker; a falling edge restarts the group phase |
| mode | input | 2 | Output format: 11 separate, 10 luma plus chroma, 01 fully interleaved, 00 reserved |
| in_luma | input | 13 | Luma sample from the core |
| in_cb | input | 13 | Blue-difference sample from the core |
| in_cr | input | 13 | Red-difference sample from the core |
| in_key | input | 13 | Key (alpha) sample from the core |
| out_w | output | 13 | Luma, or the fully interleaved stream |
| out_x | output | 13 | Blue-difference, or interleaved chroma |
| out_y | output | 13 | Red-difference (separate format only) |
| out_z | output | 13 | Delay-matched key |
| out_sync | output | 1 | Low on every clock that carries a Cb word |

## Verification
Several rules are checked on every cycle: the pass-through and key delays, zero outputs in the reserved format, zero unused ports in the interleaving formats, and Cb on X whenever the strobe is low in the luma plus chroma format. The phase state machine's restart and wrap transitions are also checked every cycle. The full word order of the fully interleaved group, the dropping of odd chroma, and re-phasing after a misaligned sync fall depend on a history of several samples. Only the bench scenarios show these, by comparing each output against a model of that history.

// File: rtl/vmux_pkg.sv
package vmux_pkg;

    typedef enum logic [1:0] {
        MODE_RSVD        = 2'b00,
        MODE_FULL        = 2'b01,
        MODE_LUMA_CHROMA = 2'b10,
        MODE_SEPARATE    = 2'b11
    } fmt_mode_e;

    typedef enum logic [1:0] {
        GRP_CB = 2'd0,
        GRP_YA = 2'd1,
        GRP_CR = 2'd2,
        GRP_YB = 2'd3
    } grp_phase_e;

endpackage

// File: rtl/vmux_delay.sv
module vmux_delay #(
    parameter int W     = 13,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[0] <= '0;
                else        stg[0] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[g] <= '0;
                else        stg[g] <= stg[g-1];
            end
        end
    end

    assign dout = stg[DEPTH-1];
endmodule

// File: rtl/vmux_phase_fsm.sv
module vmux_phase_fsm
    import vmux_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sync_in,
    output grp_phase_e phase_now
);
    logic       sync_q;
    logic       sync_fall;
    grp_phase_e state, state_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= 1'b0;
        else        sync_q <= sync_in;
    end

    assign sync_fall = sync_q & ~sync_in;

    // phase of the sample captured on this edge: restart or advance
    always_comb begin
        phase_now = sync_fall ? GRP_CB : state;
        unique case (phase_now)
            GRP_CB: state_nxt = GRP_YA;
            GRP_YA: state_nxt = GRP_CR;
            GRP_CR: state_nxt = GRP_YB;
            GRP_YB: state_nxt = GRP_CB;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= GRP_CB;
        else        state <= state_nxt;
    end

    AST_PHASE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_q && !sync_in) |=> (state == GRP_YA)); // R7
    AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!(sync_q && !sync_in) && state == GRP_YB) |=> (state == GRP_CB)); // R9
endmodule

// File: rtl/vid422_outmux.sv
module vid422_outmux
    import vmux_pkg::*;
#(
    parameter int DW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sync_in,
    input  logic [1:0]    mode,
    input  logic [DW-1:0] in_luma,
    input  logic [DW-1:0] in_cb,
    input  logic [DW-1:0] in_cr,
    input  logic [DW-1:0] in_key,
    output logic [DW-1:0] out_w,
    output logic [DW-1:0] out_x,
    output logic [DW-1:0] out_y,
    output logic [DW-1:0] out_z,
    output logic          out_sync
);
    localparam int LAT_SHORT = 2;
    localparam int LAT_LONG  = 4;
    localparam int TRIP_W    = 3 * DW;

    fmt_mode_e     fmt;
    grp_phase_e    phase_now;
    logic [TRIP_W-1:0] trip_d;
    logic [DW-1:0] d_y, d_cb, d_cr;
    logic [DW-1:0] key_short, key_long;
    logic          par_d;
    logic [DW-1:0] cr_prev;
    logic [DW-1:0] a_y, a_cb, a_cr;
    logic [DW-1:0] p_ya, p_cb, p_cr, p_yb;
    logic [DW-1:0] w_nxt, x_nxt, y_nxt, z_nxt;
    logic          sync_nxt;

    assign fmt = fmt_mode_e'(mode);

    vmux_phase_fsm u_phase (
        .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .phase_now(phase_now)
    );

    vmux_delay #(.W(TRIP_W), .DEPTH(LAT_SHORT)) u_trip (
        .clk(clk), .rst_n(rst_n), .din({in_luma, in_cb, in_cr}), .dout(trip_d)
    );

    vmux_delay #(.W(1), .DEPTH(LAT_SHORT)) u_par (
        .clk(clk), .rst_n(rst_n), .din(phase_now[0]), .dout(par_d)
    );

    vmux_delay #(.W(DW), .DEPTH(LAT_SHORT)) u_key_a (
        .clk(clk), .rst_n(rst_n), .din(in_key), .dout(key_short)
    );

    vmux_delay #(.W(DW), .DEPTH(LAT_LONG - LAT_SHORT)) u_key_b (
        .clk(clk), .rst_n(rst_n), .din(key_short), .dout(key_long)
    );

    assign d_y  = trip_d[TRIP_W-1 -: DW];
    assign d_cb = trip_d[2*DW-1 -: DW];
    assign d_cr = trip_d[DW-1:0];

    // chroma holding for the two interleaving formats
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cr_prev <= '0;
            a_y  <= '0; a_cb <= '0; a_cr <= '0;
            p_ya <= '0; p_cb <= '0; p_cr <= '0; p_yb <= '0;
        end else begin
            cr_prev <= d_cr;
            if (phase_now == GRP_CB) begin
                a_y  <= in_luma;
                a_cb <= in_cb;
                a_cr <= in_cr;
            end
            if (phase_now == GRP_YB) begin
                p_ya <= a_y;
                p_cb <= a_cb;
                p_cr <= a_cr;
                p_yb <= in_luma;
            end
        end
    end

    // output selection
    always_comb begin
        w_nxt    = '0;
        x_nxt    = '0;
        y_nxt    = '0;
        z_nxt    = '0;
        sync_nxt = 1'b1;
        unique case (fmt)
            MODE_SEPARATE: begin
                w_nxt = d_y;
                x_nxt = d_cb;
                y_nxt = d_cr;
                z_nxt = key_short;
            end
            MODE_LUMA_CHROMA: begin
                w_nxt    = d_y;
                x_nxt    = par_d ? cr_prev : d_cb;
                z_nxt    = key_short;
                sync_nxt = par_d;
            end
            MODE_FULL: begin
                unique case (phase_now)
                    GRP_CB: w_nxt = p_cb;
                    GRP_YA: w_nxt = p_ya;
                    GRP_CR: w_nxt = p_cr;
                    GRP_YB: w_nxt = p_yb;
                endcase
                z_nxt    = key_long;
                sync_nxt = (phase_now != GRP_CB);
            end
            MODE_RSVD: begin
                w_nxt = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_w    <= '0;
            out_x    <= '0;
            out_y    <= '0;
            out_z    <= '0;
            out_sync <= 1'b1;
        end else begin
            out_w    <= w_nxt;
            out_x    <= x_nxt;
            out_y    <= y_nxt;
            out_z    <= z_nxt;
            out_sync <= sync_nxt;
        end
    end

    // cycles since reset, used only to qualify the history-based checks
    logic [2:0] age;
    logic       warm;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           age <= '0;
        else if (age != 3'd7) age <= age + 3'd1;
    end
    assign warm = (age >= 3'd5);

    AST_SEP_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $past(mode) == 2'b11) |->
        (out_w == $past(in_luma, 3) && out_x == $past(in_cb, 3) && out_y == $past(in_cr, 3))); // R2
    AST_LC_Y_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $past(mode) == 2'b10) |-> (out_y == '0)); // R3
    AST_LC_CB_ON_X: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $past(mode) == 2'b10 && !out_sync) |-> (out_x == $past(in_cb, 3))); // R8
    AST_FULL_XY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $past(mode) == 2'b01) |-> (out_x == '0 && out_y == '0)); // R4
    AST_KEY_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $past(mode[1])) |-> (out_z == $past(in_key, 3))); // R5
    AST_KEY_LONG: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $past(mode) == 2'b01) |-> (out_z == $past(in_key, 5))); // R5
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $past(mode) == 2'b00) |->
        (out_w == '0 && out_x == '0 && out_y == '0 && out_z == '0)); // R6
    AST_SYNC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $past(mode[0]) == $past(mode[1])) |-> out_sync); // R8
endmodule

// File: tb/sim_vid422_outmux.sv
`timescale 1ns/1ps
module sim_vid422_outmux;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sync_in = 1'b1;
    logic [1:0]  mode = 2'b11;
    logic [12:0] in_luma = '0, in_cb = '0, in_cr = '0, in_key = '0;
    logic [12:0] out_w, out_x, out_y, out_z;
    logic        out_sync;

    int nchk = 0;
    int nerr = 0;
    int cyc  = 0;
    bit done = 0;

    logic [12:0] hy [512];
    logic [12:0] hcb[512];
    logic [12:0] hcr[512];
    logic [12:0] hk [512];
    logic        hs [512];
    logic [1:0]  hm [512];

    vid422_outmux u0 (
        .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .mode(mode),
        .in_luma(in_luma), .in_cb(in_cb), .in_cr(in_cr), .in_key(in_key),
        .out_w(out_w), .out_x(out_x), .out_y(out_y), .out_z(out_z),
        .out_sync(out_sync)
    );

    always #4 clk = ~clk;

    // separate-format vectors: {luma, cb, cr, key}; expected W,X,Y,Z equal them 2 clocks later
    localparam logic [51:0] VEC [12] = '{
        {13'd0,    13'd8191, 13'd1,    13'd4096},
        {13'd8191, 13'd0,    13'd8190, 13'd1},
        {13'd1234, 13'd2345, 13'd3456, 13'd4567},
        {13'd5555, 13'd4444, 13'd3333, 13'd2222},
        {13'd1,    13'd2,    13'd4,    13'd8},
        {13'd4095, 13'd2048, 13'd1024, 13'd512},
        {13'd7000, 13'd6000, 13'd5000, 13'd4000},
        {13'd17,   13'd170,  13'd1700, 13'd7100},
        {13'd8000, 13'd7,    13'd800,  13'd70},
        {13'd2730, 13'd5461, 13'd2730, 13'd5461},
        {13'd300,  13'd301,  13'd302,  13'd303},
        {13'd99,   13'd98,   13'd97,   13'd96}
    };

    task automatic chk(string tag, logic [12:0] act, logic [12:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int last_fall(int j);
        for (int k = j; k >= 1; k--)
            if (hs[k] == 1'b0 && hs[k-1] == 1'b1) return k;
        return 0;
    endfunction

    task automatic check_step(int i);
        int j, f, p, g;
        bit even;
        if (i < 5) return;
        case (hm[i])
            2'b11: begin
                chk("R2 out_w", out_w, hy[i-2]);
                chk("R2 out_x", out_x, hcb[i-2]);
                chk("R2 out_y", out_y, hcr[i-2]);
                chk("R5 out_z", out_z, hk[i-2]);
                chk("R8 out_sync", {12'd0, out_sync}, 13'd1);
            end
            2'b10: begin
                j = i - 2;
                f = last_fall(j);
                even = ((j - f) % 2) == 0;
                chk("R3 out_w", out_w, hy[j]);
                chk(f == 0 ? "R3 R9 out_x" : "R3 R7 out_x", out_x, even ? hcb[j] : hcr[j-1]);
                chk("R3 out_y", out_y, 13'd0);
                chk("R5 out_z", out_z, hk[j]);
                chk(f == 0 ? "R8 R9 out_sync" : "R8 R7 out_sync",
                    {12'd0, out_sync}, even ? 13'd0 : 13'd1);
            end
            2'b01: begin
                f = last_fall(i);
                p = (i - f) % 4;
                g = i - p - 4;
                chk("R4 out_x", out_x, 13'd0);
                chk("R4 out_y", out_y, 13'd0);
                chk("R5 out_z", out_z, hk[i-4]);
                if (g >= f) begin
                    case (p)
                        0: chk("R4 R7 out_w Cb", out_w, hcb[g]);
                        1: chk("R4 R7 out_w Ya", out_w, hy[g]);
                        2: chk("R4 R7 out_w Cr", out_w, hcr[g]);
                        default: chk("R4 R7 out_w Yb", out_w, hy[g+3]);
                    endcase
                    chk("R8 out_sync", {12'd0, out_sync}, (p == 0) ? 13'd0 : 13'd1);
                end
            end
            default: begin
                chk("R6 out_w", out_w, 13'd0);
                chk("R6 out_x", out_x, 13'd0);
                chk("R6 out_y", out_y, 13'd0);
                chk("R6 out_z", out_z, 13'd0);
                chk("R6 out_sync", {12'd0, out_sync}, 13'd1);
            end
        endcase
    endtask

    task automatic step(logic [12:0] y, logic [12:0] cb, logic [12:0] cr,
                        logic [12:0] k, logic s, logic [1:0] m);
        in_luma = y; in_cb = cb; in_cr = cr; in_key = k; sync_in = s; mode = m;
        hy[cyc] = y; hcb[cyc] = cb; hcr[cyc] = cr; hk[cyc] = k; hs[cyc] = s; hm[cyc] = m;
        @(negedge clk);
        cyc++;
        check_step(cyc - 1);
    endtask

    task automatic check_reset_state();
        chk("R1 out_w", out_w, 13'd0);
        chk("R1 out_x", out_x, 13'd0);
        chk("R1 out_y", out_y, 13'd0);
        chk("R1 out_z", out_z, 13'd0);
        chk("R1 out_sync", {12'd0, out_sync}, 13'd1);
    endtask

    initial begin
        in_luma = 13'd11; in_cb = 13'd22; in_cr = 13'd33; in_key = 13'd44;
        repeat (3) @(negedge clk);
        check_reset_state();
        rst_n = 1'b1;
        cyc = 0;

        // R2, R5: vector table in separate format
        foreach (VEC[n])
            step(VEC[n][51:39], VEC[n][38:26], VEC[n][25:13], VEC[n][12:0], 1'b1, 2'b11);

        // R3, R9: luma plus chroma, free-running phase from reset
        for (int n = 0; n < 8; n++)
            step(13'(100 + n), 13'(200 + n), 13'(300 + n), 13'(400 + n), 1'b1, 2'b10);
        // R7: sync fall, then a second fall on an odd offset
        for (int n = 0; n < 9; n++)
            step(13'(500 + n), 13'(600 + n), 13'(700 + n), 13'(800 + n), 1'b0, 2'b10);
        step(13'd900, 13'd901, 13'd902, 13'd903, 1'b1, 2'b10);
        for (int n = 0; n < 9; n++)
            step(13'(1000 + n), 13'(1100 + n), 13'(1200 + n), 13'(1300 + n), 1'b0, 2'b10);

        // R4, R5, R8: fully interleaved, half-rate inputs held two clocks
        step(13'd1400, 13'd1401, 13'd1402, 13'd1403, 1'b1, 2'b01);
        for (int n = 0; n < 12; n++) begin
            step(13'(2000 + n), 13'(3000 + n), 13'(4000 + n), 13'(5000 + n), 1'b0, 2'b01);
            step(13'(2000 + n), 13'(3000 + n), 13'(4000 + n), 13'(5000 + n), 1'b0, 2'b01);
        end
        // R7: re-phase the group on a fresh fall
        step(13'd2500, 13'd3500, 13'd4500, 13'd5500, 1'b1, 2'b01);
        for (int n = 0; n < 8; n++) begin
            step(13'(6000 + n), 13'(6100 + n), 13'(6200 + n), 13'(6300 + n), 1'b0, 2'b01);
            step(13'(6000 + n), 13'(6100 + n), 13'(6200 + n), 13'(6300 + n), 1'b0, 2'b01);
        end

        // R6: reserved format
        for (int n = 0; n < 6; n++)
            step(13'(7000 + n), 13'(7100 + n), 13'(7200 + n), 13'(7300 + n), 1'b1, 2'b00);

        // R1: reset in mid-run
        for (int n = 0; n < 4; n++)
            step(13'(50 + n), 13'(60 + n), 13'(70 + n), 13'(80 + n), 1'b1, 2'b11);
        rst_n = 1'b0;
        #1;
        check_reset_state();
        @(negedge clk);
        check_reset_state();
        rst_n = 1'b1;
        cyc = 0;
        for (int n = 0; n < 8; n++)
            step(13'(150 + n), 13'(160 + n), 13'(170 + n), 13'(180 + n), 1'b1, 2'b11);

        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end
endmodule